// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a serial flash device from a small set of host registers. Each write to the command register starts one segment of a flash transaction. The segment sends an 8-bit opcode, then zero to three address bytes (most significant byte first), then zero to fifteen dummy clock cycles, and then zero to four data bytes. Data bytes are either sent from the data register or captured into it. The serial clock idles high and the flash samples on its rising edge (SPI mode 3), with one data line in each direction. The period of the serial clock, its falling and rising edge positions and the read-sample point are all set in controller clock cycles.

A keep-select bit leaves the chosen chip select asserted when a segment ends. Host software can then split a long flash transaction into several command writes. When a command arrives while chip select is still held, it continues the open transaction and no opcode is sent. A continuation with no address, no dummy cycles, no data and keep-select clear sends no clocks and only releases chip select. An illegal command sets a sticky error flag and is dropped. A command is illegal if it is written while one is running, if its lengths are out of range, or if it names a different chip select while one is held.

Top module: `sfseq_top`

## Requirements
- R1: After reset the serial clock is high, every chip select is high (inactive), the status word reads 0 and the timing register reads 0x0003_0204 (period 4, rise at 2, fall at 0, sample at 3).
- R2: Command word fields are: opcode [7:0], write flag bit 8, data byte count [11:9], keep-select bit 15, dummy cycles [19:16], address byte count [22:20] and chip-select index [26:24]. One command clocks, in this order, the opcode MSB first, the lowest `count` bytes of the address register MSB first, the dummy cycles and the data bits. A phase whose length is zero produces no clock edges.
- R3: In a write command (bit 8 set), data byte k goes out from data-register bits [8k+7:8k], with byte 0 first and each byte MSB first.
- R4: In a read command (bit 8 clear), the bit sampled in data-stream position i is stored at data-register bit 8*(i/8) + 7 - (i mod 8). All other bits of the data register become 0 when the command ends.
- R5: With keep-select set, the chip select stays low after the command. A following command on the same index sends no opcode and continues the transaction.
- R6: With keep-select clear, the chip select goes high at the end. A continuation with zero address, dummy and data lengths makes no clock edges and only releases the chip select.
- R7: Status bit 22 (pending) reads 1 from the cycle after a command is accepted until that command ends.
- R8: A command written while one is pending sets status bit 29 (error) and is discarded without any effect on the serial lines.
- R9: Writing 1 to status bit 29 clears the error. Writing 0 leaves it set.
- R10: A command with a data count above 4, an address count above 3, a chip-select index at or above the number of selects, or (while a select is held) a different index sets the error and is discarded. Chip selects and clock stay unchanged.
- R11: While a bit is being shifted, the serial clock has a period of max(2, period field [3:0]) cycles. It goes low at count [15:12] and high at count [11:8]. It is high whenever no command runs.
- R12: Chip select `cs_n[i]` goes low only for index i, and at most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_addr | input | 3 | Register index: 0 command, 1 address, 2 data, 3 status, 4 timing |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data of the register chosen by bus_addr |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | NCS | Active-low chip selects |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A phase counter that is wrong by one shows up in the same segment as a wrong number of rising clock edges and a shifted MOSI stream. A behavioural flash on the bench counts those edges and checks opcode, address and data bits position by position. A read-side index error gives data-register contents that do not match the flash's known bit pattern as soon as the segment ends. A wrong hold state for the select shows on `cs_n` when the segment ends, or as a missing or repeated opcode in the next segment. A rejection that leaks shows as extra clock edges, or as a status word without the error bit, within a few cycles of the illegal write.

// File: rtl/sfseq_pkg.sv
`timescale 1ns/1ps
package sfseq_pkg;
    localparam int STAT_PEND_BIT = 22;
    localparam int STAT_ERR_BIT  = 29;
    localparam int ADDR_MAX      = 3;
    localparam int DATA_MAX      = 4;

    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_ADDR = 3'd1;
    localparam logic [2:0] RA_DATA = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_TIME = 3'd4;

    typedef logic [2:0] phase_t;
    localparam phase_t PH_OPC   = 3'd0;
    localparam phase_t PH_ADDR  = 3'd1;
    localparam phase_t PH_DUMMY = 3'd2;
    localparam phase_t PH_DATA  = 3'd3;
    localparam phase_t PH_NONE  = 3'd4;

    // command fields the engine consumes (reserved bits stripped)
    typedef struct packed {
        logic [2:0] cs;
        logic [2:0] alen;
        logic [3:0] dum;
        logic       keep;
        logic [2:0] dlen;
        logic       wr;
        logic [7:0] opc;
    } cmd_f_t;

    // timing fields, all in controller clock cycles
    typedef struct packed {
        logic [3:0] smp;
        logic [3:0] fall;
        logic [3:0] rise;
        logic [3:0] per;
    } tim_f_t;

    localparam tim_f_t TIM_RESET = '{smp: 4'd3, fall: 4'd0, rise: 4'd2, per: 4'd4};

    // bit lengths of the four phases of one segment
    typedef struct packed {
        logic [5:0] opc;
        logic [5:0] addr;
        logic [5:0] dum;
        logic [5:0] data;
    } lens_t;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_SHIFT, ST_DONE} state_e;

    function automatic lens_t lens_of(cmd_f_t c, logic cont);
        lens_t l;
        l.opc  = cont ? 6'd0 : 6'd8;
        l.addr = {c.alen, 3'b000};
        l.dum  = {2'b00, c.dum};
        l.data = {c.dlen, 3'b000};
        return l;
    endfunction

    function automatic logic [5:0] phase_len(phase_t ph, lens_t l);
        case (ph)
            PH_OPC:   return l.opc;
            PH_ADDR:  return l.addr;
            PH_DUMMY: return l.dum;
            PH_DATA:  return l.data;
            default:  return 6'd0;
        endcase
    endfunction

    // first phase at or after 'from' with a nonzero length
    function automatic phase_t next_phase(phase_t from, lens_t l);
        phase_t r = PH_NONE;
        logic   found = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (!found && (3'(i) >= from) && (phase_len(3'(i), l) != 6'd0)) begin
                r     = 3'(i);
                found = 1'b1;
            end
        end
        return r;
    endfunction

    // little-endian byte order, MSB first within each byte
    function automatic logic [4:0] data_bit_idx(logic [4:0] pos);
        return {pos[4:3], ~pos[2:0]};
    endfunction
endpackage

// File: rtl/sfseq_regs.sv
`timescale 1ns/1ps
module sfseq_regs
    import sfseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        busy,
    input  logic        reject,
    input  logic        rd_load,
    input  logic [31:0] rd_data,
    output logic        cmd_wr,
    output cmd_f_t      cmd_f,
    output logic [23:0] addr_q,
    output logic [31:0] data_q,
    output tim_f_t      tim_q
);
    logic [31:0] cmd_q;
    logic        err_q;
    logic [31:0] stat_w;

    assign cmd_wr = bus_wr && (bus_addr == RA_CMD);
    assign cmd_f  = '{cs: bus_wdata[26:24], alen: bus_wdata[22:20], dum: bus_wdata[19:16],
                      keep: bus_wdata[15], dlen: bus_wdata[11:9], wr: bus_wdata[8],
                      opc: bus_wdata[7:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            tim_q  <= TIM_RESET;
            err_q  <= 1'b0;
        end else begin
            if (cmd_wr) cmd_q <= bus_wdata;
            if (bus_wr && bus_addr == RA_ADDR) addr_q <= bus_wdata[23:0];
            if (rd_load) data_q <= rd_data;
            else if (bus_wr && bus_addr == RA_DATA) data_q <= bus_wdata;
            if (bus_wr && bus_addr == RA_TIME)
                tim_q <= '{smp: bus_wdata[19:16], fall: bus_wdata[15:12],
                           rise: bus_wdata[11:8], per: bus_wdata[3:0]};
            if (reject) err_q <= 1'b1;
            else if (bus_wr && bus_addr == RA_STAT && bus_wdata[STAT_ERR_BIT]) err_q <= 1'b0;
        end
    end

    always_comb begin
        stat_w                = '0;
        stat_w[STAT_PEND_BIT] = busy;
        stat_w[STAT_ERR_BIT]  = err_q;
    end

    always_comb begin
        case (bus_addr)
            RA_CMD:  bus_rdata = cmd_q;
            RA_ADDR: bus_rdata = {8'h00, addr_q};
            RA_DATA: bus_rdata = data_q;
            RA_STAT: bus_rdata = stat_w;
            RA_TIME: bus_rdata = {12'h000, tim_q.smp, tim_q.fall, tim_q.rise, 4'h0, tim_q.per};
            default: bus_rdata = '0;
        endcase
    end

    assert_err_on_reject_R8: assert property (@(posedge clk) disable iff (rst)
        reject |=> err_q);
    assert_err_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_STAT && bus_wdata[STAT_ERR_BIT] && !reject) |=> !err_q);
endmodule

// File: rtl/sfseq_sck.sv
`timescale 1ns/1ps
module sfseq_sck
    import sfseq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  tim_f_t tim,
    output logic   sck,
    output logic   cell_start,
    output logic   cell_end,
    output logic   smp
);
    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_eff;

    assign per_eff    = (tim.per < MIN_PER) ? MIN_PER : tim.per;
    assign cell_start = run && (cnt == '0);
    assign cell_end   = run && (cnt == per_eff - CNT_W'(1));
    assign smp        = run && (cnt == tim.smp);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else begin
            cnt <= cell_end ? '0 : cnt + CNT_W'(1);
            if (cnt == tim.fall)      sck <= 1'b0;
            else if (cnt == tim.rise) sck <= 1'b1;
        end
    end

    assert_sck_fall_only_running_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(sck) |-> $past(run));
endmodule

// File: rtl/sfseq_engine.sv
`timescale 1ns/1ps
module sfseq_engine
    import sfseq_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_wr,
    input  cmd_f_t         cmd_f,
    input  logic [23:0]    addr_word,
    input  logic [31:0]    data_word,
    input  logic           cell_start,
    input  logic           cell_end,
    input  logic           smp,
    input  logic           sck_in,
    input  logic           miso,
    output logic           run,
    output logic           busy,
    output logic           reject,
    output logic           rd_load,
    output logic [31:0]    rd_data,
    output logic           mosi,
    output logic [NCS-1:0] cs_n
);
    state_e      state;
    phase_t      phase;
    logic [5:0]  pos;
    lens_t       lens;
    logic [7:0]  cur_opc;
    logic        cur_wr;
    logic        cur_keep;
    logic [23:0] tx_addr;
    logic [31:0] tx_data;
    logic [31:0] rx_data;
    logic        cs_active;
    logic [2:0]  cs_idx;
    logic        mosi_q;

    logic        bad_fields;
    logic        accept;
    lens_t       new_lens;
    phase_t      first_ph;
    logic [5:0]  addr_idx;
    logic        tx_bit;
    logic        last_bit;
    phase_t      after_ph;

    assign bad_fields = (cmd_f.dlen > 3'(DATA_MAX)) || (cmd_f.alen > 3'(ADDR_MAX))
                     || (int'(cmd_f.cs) >= NCS)
                     || (cs_active && (cmd_f.cs != cs_idx));
    assign reject   = cmd_wr && ((state != ST_IDLE) || bad_fields);
    assign accept   = cmd_wr && !reject;
    assign new_lens = lens_of(cmd_f, cs_active);
    assign first_ph = next_phase(PH_OPC, new_lens);

    assign addr_idx = lens.addr - 6'd1 - pos;
    assign last_bit = (pos + 6'd1) == phase_len(phase, lens);
    assign after_ph = next_phase(phase + 3'd1, lens);

    always_comb begin
        case (phase)
            PH_OPC:  tx_bit = cur_opc[~pos[2:0]];
            PH_ADDR: tx_bit = tx_addr[addr_idx[4:0]];
            PH_DATA: tx_bit = cur_wr & tx_data[data_bit_idx(pos[4:0])];
            default: tx_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_NONE;
            pos       <= '0;
            lens      <= '0;
            cur_opc   <= '0;
            cur_wr    <= 1'b0;
            cur_keep  <= 1'b0;
            tx_addr   <= '0;
            tx_data   <= '0;
            rx_data   <= '0;
            cs_active <= 1'b0;
            cs_idx    <= '0;
            mosi_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    lens      <= new_lens;
                    cur_opc   <= cmd_f.opc;
                    cur_wr    <= cmd_f.wr;
                    cur_keep  <= cmd_f.keep;
                    tx_addr   <= addr_word;
                    tx_data   <= data_word;
                    rx_data   <= '0;
                    phase     <= first_ph;
                    pos       <= '0;
                    cs_active <= 1'b1;
                    cs_idx    <= cmd_f.cs;
                    state     <= (first_ph == PH_NONE) ? ST_DONE : ST_START;
                end
                ST_START: state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (cell_start) mosi_q <= tx_bit;
                    if (smp && phase == PH_DATA && !cur_wr)
                        rx_data[data_bit_idx(pos[4:0])] <= miso;
                    if (cell_end) begin
                        if (last_bit) begin
                            phase <= after_ph;
                            pos   <= '0;
                            if (after_ph == PH_NONE) state <= ST_DONE;
                        end else begin
                            pos <= pos + 6'd1;
                        end
                    end
                end
                ST_DONE: begin
                    if (!cur_keep) cs_active <= 1'b0;
                    mosi_q <= 1'b0;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run     = (state == ST_SHIFT);
    assign busy    = (state != ST_IDLE);
    assign rd_load = (state == ST_DONE) && !cur_wr && (lens.data != 6'd0);
    assign rd_data = rx_data;
    assign mosi    = mosi_q;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(cs_active && (cs_idx == 3'(g)));
    end

    assert_cs_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_pend_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    assert_reject_no_start_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && reject) |=> (!busy && $stable(cs_n)));
    assert_idle_sck_high_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck_in);
endmodule

// File: rtl/sfseq_top.sv
`timescale 1ns/1ps
module sfseq_top
    import sfseq_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [2:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           sck,
    output logic [NCS-1:0] cs_n,
    output logic           mosi,
    input  logic           miso
);
    logic        cmd_wr, busy, reject, rd_load, run;
    logic        cell_start, cell_end, smp;
    cmd_f_t      cmd_f;
    tim_f_t      tim_q;
    logic [23:0] addr_q;
    logic [31:0] data_q, rd_data;

    sfseq_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .reject(reject), .rd_load(rd_load), .rd_data(rd_data),
        .cmd_wr(cmd_wr), .cmd_f(cmd_f), .addr_q(addr_q), .data_q(data_q),
        .tim_q(tim_q)
    );

    sfseq_sck #(.CNT_W(4)) u_sck (
        .clk(clk), .rst(rst), .run(run), .tim(tim_q), .sck(sck),
        .cell_start(cell_start), .cell_end(cell_end), .smp(smp)
    );

    sfseq_engine #(.NCS(NCS)) u_eng (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_f(cmd_f),
        .addr_word(addr_q), .data_word(data_q), .cell_start(cell_start),
        .cell_end(cell_end), .smp(smp), .sck_in(sck), .miso(miso),
        .run(run), .busy(busy), .reject(reject), .rd_load(rd_load),
        .rd_data(rd_data), .mosi(mosi), .cs_n(cs_n)
    );
endmodule

// File: tb/tb_sfseq_top.sv
`timescale 1ns/1ps
module tb_sfseq_top;
    localparam int NCS = 4;
    localparam logic [2:0] A_CMD = 3'd0, A_ADDR = 3'd1, A_DATA = 3'd2, A_STAT = 3'd3, A_TIME = 3'd4;
    localparam int NV = 9;
    // {command, address, write data, expected clock edges}
    localparam logic [127:0] VECS [NV] = '{
        {32'h00000006, 32'h00000000, 32'h00000000, 32'd8},
        {32'h02300803, 32'h00123456, 32'hFFFFFFFF, 32'd64},
        {32'h0138840B, 32'h00ABCDEF, 32'h00000000, 32'd56},
        {32'h01008800, 32'h00000000, 32'h00000000, 32'd32},
        {32'h01000000, 32'h00000000, 32'h00000000, 32'd0},
        {32'h03308902, 32'h00000100, 32'hDDCCBBAA, 32'd64},
        {32'h03000700, 32'h00000000, 32'h00332211, 32'd24},
        {32'h00200320, 32'h0000BEEF, 32'h0000005A, 32'd32},
        {32'h0013029F, 32'h00000042, 32'hFFFFFFFF, 32'd27}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 1'b0;
    logic [2:0]     bus_addr = 3'd0;
    logic [31:0]    bus_wdata = 32'd0;
    logic [31:0]    bus_rdata;
    logic           sck, mosi;
    logic [NCS-1:0] cs_n;
    logic           miso = 1'b0;

    int  checks = 0, errors = 0;
    int  cyc = 0;
    int  gcnt = 0;
    int  sess_base = 0;
    int  fall_prev = 0, fall_last = 0;
    logic held = 1'b0;
    logic log_mem [0:4095];

    sfseq_top #(.NCS(NCS)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    function automatic logic pat(int n);
        return n[0] ^ n[1] ^ n[3];
    endfunction

    // flash model: samples MOSI on rising SCK, shifts MISO out on falling SCK
    always @(posedge sck) begin
        if (!rst && (cs_n != '1)) begin
            log_mem[gcnt % 4096] <= mosi;
            gcnt <= gcnt + 1;
        end
    end
    always @(negedge sck) begin
        if (!rst && (cs_n != '1)) begin
            miso      <= pat(gcnt - sess_base);
            fall_prev <= fall_last;
            fall_last <= cyc;
        end
    end

    task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        do begin rd(A_STAT, s); n++; end while (s[22] && n < 5000);
        if (n >= 5000) chk(1'b0, "R7", s, 32'h0);
    endtask

    // compares an opcode's 8 bits at log position p0
    function automatic int opc_bad(int p0, logic [7:0] op);
        int b = 0;
        for (int i = 0; i < 8; i++) if (log_mem[(p0 + i) % 4096] !== op[7 - i]) b++;
        return b;
    endfunction

    task automatic run_vec(input logic [31:0] c, input logic [23:0] a, input logic [31:0] wd, input int exp_e);
        int seg0, p, bad, al, dm, dl, base;
        logic [31:0] got, exp_rd, exp_cs;
        wr(A_ADDR, {8'h00, a});
        wr(A_DATA, wd);
        if (!held) sess_base = gcnt;
        seg0 = gcnt;
        wr(A_CMD, c);
        wait_idle();
        chk(gcnt - seg0 == exp_e, "R2 edge count", 32'(gcnt - seg0), 32'(exp_e));
        al = int'(c[22:20]) * 8; dm = int'(c[19:16]); dl = int'(c[11:9]) * 8;
        bad = 0; p = 0;
        if (!held) begin bad += opc_bad(seg0, c[7:0]); p = 8; end   // R5: no opcode on continuation
        for (int i = 0; i < al; i++) begin
            if (log_mem[(seg0 + p) % 4096] !== a[al - 1 - i]) bad++;
            p++;
        end
        p += dm;
        base = seg0 + p - sess_base;
        if (c[8]) for (int i = 0; i < dl; i++) begin
            if (log_mem[(seg0 + p + i) % 4096] !== wd[{i[4:3], ~i[2:0]}]) bad++;
        end
        chk(bad == 0, c[8] ? "R3 write stream" : "R2 phase stream", 32'(bad), 32'h0);
        if (!c[8] && dl > 0) begin
            exp_rd = '0;
            for (int i = 0; i < dl; i++) exp_rd[{i[4:3], ~i[2:0]}] = pat(base + i);
            rd(A_DATA, got);
            chk(got == exp_rd, "R4 read data", got, exp_rd);
        end
        held = c[15];
        exp_cs = held ? 32'(~(4'b0001 << c[25:24])) & 32'hF : 32'hF;
        chk({28'h0, cs_n} == exp_cs, held ? "R5 select held" : "R6 select released", {28'h0, cs_n}, exp_cs);
    endtask

    initial begin
        logic [31:0] v;
        int g0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(A_STAT, v); chk(v == 32'h0, "R1 status", v, 32'h0);
        rd(A_TIME, v); chk(v == 32'h00030204, "R1 timing", v, 32'h00030204);
        chk(sck === 1'b1, "R1 sck", {31'h0, sck}, 32'h1);
        chk(cs_n === '1, "R1 cs_n", {28'h0, cs_n}, 32'hF);

        for (int k = 0; k < NV; k++)
            run_vec(VECS[k][127:96], VECS[k][87:64], VECS[k][63:32], int'(VECS[k][31:0]));

        // R7 pending and R8 reject while pending
        g0 = gcnt; sess_base = gcnt;
        wr(A_CMD, 32'h00000006);
        rd(A_STAT, v); chk(v[22], "R7 pending", v, 32'h00400000);
        wr(A_CMD, 32'h00000099);
        wait_idle();
        chk(gcnt - g0 == 8, "R8 discarded edges", 32'(gcnt - g0), 32'd8);
        chk(opc_bad(g0, 8'h06) == 0, "R8 opcode kept", 32'(opc_bad(g0, 8'h06)), 32'h0);
        rd(A_STAT, v); chk(v == 32'h20000000, "R8 error set", v, 32'h20000000);
        // R9 write-one-to-clear
        wr(A_STAT, 32'h0); rd(A_STAT, v); chk(v[29], "R9 zero keeps", v, 32'h20000000);
        wr(A_STAT, 32'h20000000); rd(A_STAT, v); chk(v == 32'h0, "R9 cleared", v, 32'h0);

        // R10 illegal data count
        g0 = gcnt;
        wr(A_CMD, 32'h00000A05);
        repeat (20) @(negedge clk);
        rd(A_STAT, v); chk(v == 32'h20000000, "R10 dlen error", v, 32'h20000000);
        chk(gcnt == g0 && cs_n === '1, "R10 no activity", 32'(gcnt - g0), 32'h0);
        wr(A_STAT, 32'h20000000);
        // R10 select mismatch while held
        sess_base = gcnt;
        wr(A_CMD, 32'h01008006); wait_idle();
        wr(A_CMD, 32'h02000000);
        repeat (10) @(negedge clk);
        rd(A_STAT, v); chk(v[29], "R10 mismatch error", v, 32'h20000000);
        chk(cs_n === 4'b1101, "R10 select unchanged", {28'h0, cs_n}, 32'hD);
        wr(A_STAT, 32'h20000000);
        g0 = gcnt;
        wr(A_CMD, 32'h01000000); wait_idle();
        chk(cs_n === '1 && gcnt == g0, "R6 release only", {28'h0, cs_n}, 32'hF);

        // R11 custom timing, R12 select index
        wr(A_TIME, 32'h00051406);
        rd(A_TIME, v); chk(v == 32'h00051406, "R11 timing readback", v, 32'h00051406);
        g0 = gcnt; sess_base = gcnt;
        wr(A_CMD, 32'h000000A5);
        repeat (3) @(negedge clk);
        chk(cs_n === 4'b1110, "R12 select index", {28'h0, cs_n}, 32'hE);
        wait_idle();
        chk(gcnt - g0 == 8 && opc_bad(g0, 8'hA5) == 0, "R11 bits at new timing", 32'(gcnt - g0), 32'd8);
        chk(fall_last - fall_prev == 6, "R11 period", 32'(fall_last - fall_prev), 32'd6);
        chk(sck === 1'b1, "R11 idle high", {31'h0, sck}, 32'h1);
        wr(A_TIME, 32'h00030204);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule